// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address for a four-beat burst. A base address is captured from an external address bus when either of two active-low load strobes is low at a rising clock edge. One strobe belongs to the processor side and one to the controller side. Once a burst is loaded, an active-low step input moves it to the next beat. Only the two least significant address bits change from beat to beat. The upper bits keep the loaded value until the next load.

An ordering input chooses how the beats are arranged. In interleaved order, the low bits are the loaded low bits XOR the beat index. In linear order, they are the loaded low bits plus the beat index, wrapping modulo four. The ordering input is registered, so a change reaches the generated address one cycle late. The beat index is output alongside the full address.

Top module: `burst_seq`

## Requirements
- R1: After reset, `addr_out` is all zeros, `beat` is 0 and interleaved order is selected.
- R2: When `ld_cpu_n` is low at a rising edge, the base address is taken from `addr_in` and `beat` becomes 0 after that edge.
- R3: When `ld_ctl_n` is low at a rising edge, the base address is taken from `addr_in` and `beat` becomes 0 after that edge.
- R4: When both load strobes are low at the same edge, a load takes place and `step_n` has no effect on that edge.
- R5: When neither strobe is low and `step_n` is low at a rising edge, `beat` increases by one.
- R6: With interleaved order (registered `order_lin` = 0), `addr_out[1:0]` equals the loaded low bits XOR `beat`.
- R7: With linear order (registered `order_lin` = 1), `addr_out[1:0]` equals the loaded low bits plus `beat`, modulo 4.
- R8: A step taken from beat 3 returns `beat` to 0 and leaves the upper address bits unchanged.
- R9: When neither strobe is low and `step_n` is high, `beat` and the loaded base keep their values.
- R10: A value on `order_lin` is sampled at a rising edge and first affects `addr_out` after that edge.
- R11: `addr_out[ADDR_W-1:2]` changes only on an edge where a load strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | ADDR_W | External base address |
| ld_cpu_n | input | 1 | Processor-side load strobe, active low, highest priority |
| ld_ctl_n | input | 1 | Controller-side load strobe, active low |
| step_n | input | 1 | Active-low beat advance |
| order_lin | input | 1 | 1 selects linear order, 0 selects interleaved order |
| addr_out | output | ADDR_W | Current burst word address |
| beat | output | 2 | Current beat index, 0 to 3 |

## Verification
The bench builds the sequencer with `ADDR_W` = 8. This keeps the upper field to six bits, so random loads often repeat upper values. That exposes a stuck or carried upper field. It also lets every pairing of base low bits, beat and order occur many times.

A directed phase covers each strobe, their overlap, wrap-around and a mode change in the middle of a burst. It is followed by a long random phase in which strobes, steps and ordering changes collide in every combination.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ld_cpu_n,
  input  logic              ld_ctl_n,
  input  logic              step_n,
  input  logic              order_lin,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        beat
);

  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic              lin_q;
  logic              load;
  logic [1:0]        low_ilv;
  logic [1:0]        low_lin;

  // processor strobe has priority; either strobe results in a load
  assign load = !ld_cpu_n || !ld_ctl_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      lin_q  <= 1'b0;
    end else begin
      lin_q <= order_lin;
      if (!ld_cpu_n) begin
        base_q <= addr_in;
        cnt_q  <= '0;
      end else if (!ld_ctl_n) begin
        base_q <= addr_in;
        cnt_q  <= '0;
      end else if (!step_n) begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  assign low_ilv  = base_q[1:0] ^ cnt_q;
  assign low_lin  = base_q[1:0] + cnt_q;
  assign addr_out = {base_q[ADDR_W-1:2], lin_q ? low_lin : low_ilv};
  assign beat     = cnt_q;

  assert_load_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (beat == 2'd0) && (addr_out[ADDR_W-1:2] == $past(addr_in[ADDR_W-1:2])));

  assert_load_both_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_cpu_n && !ld_ctl_n && !step_n) |=> beat == 2'd0);

  assert_step_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step_n) |=> beat == $past(beat) + 2'd1);

  assert_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step_n) |=> $stable(beat));

  assert_upper_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(addr_out[ADDR_W-1:2]));

  assert_first_beat_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr_out[1:0] == $past(addr_in[1:0]));

endmodule

// File: tb/burst_seq_bench.sv
module burst_seq_bench;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_in;
  logic          ld_cpu_n, ld_ctl_n, step_n, order_lin;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat;

  int vectors = 0;
  int errors  = 0;
  int m_base  = 0;
  int m_cnt   = 0;
  int m_lin   = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  burst_seq #(.ADDR_W(AW)) u_burst_seq (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .ld_cpu_n(ld_cpu_n),
    .ld_ctl_n(ld_ctl_n), .step_n(step_n), .order_lin(order_lin),
    .addr_out(addr_out), .beat(beat)
  );

  function automatic int exp_addr();
    int lo;
    if (m_lin != 0) lo = ((m_base % 4) + m_cnt) % 4;
    else            lo = (m_base % 4) ^ m_cnt;
    return (m_base / 4) * 4 + lo;
  endfunction

  task automatic step(input string tag);
    @(posedge clk);
    if (!rst_n) begin
      m_base = 0; m_cnt = 0; m_lin = 0;
    end else begin
      m_lin = int'(order_lin);
      if (!ld_cpu_n || !ld_ctl_n) begin
        m_base = int'(addr_in); m_cnt = 0;
      end else if (!step_n) begin
        m_cnt = (m_cnt + 1) % 4;
      end
    end
    @(negedge clk);
    vectors++;
    if (int'(addr_out) != exp_addr() || int'(beat) != m_cnt) begin
      errors++;
      $display("FAIL %s: addr=%0h beat=%0d expected addr=%0h beat=%0d",
               tag, addr_out, beat, exp_addr(), m_cnt);
    end
  endtask

  task automatic drive(input logic cpu, input logic ctl, input logic stp,
                       input logic lin, input logic [AW-1:0] a, input string tag);
    ld_cpu_n = cpu; ld_ctl_n = ctl; step_n = stp; order_lin = lin; addr_in = a;
    step(tag);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: expired expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ld_cpu_n = 1'b1; ld_ctl_n = 1'b1; step_n = 1'b1;
    order_lin = 1'b1; addr_in = 8'hA7;
    @(negedge clk);
    step("R1 reset");
    step("R1 reset");
    rst_n = 1'b1;
    drive(1, 1, 1, 0, 8'h00, "R1 idle after reset");
    // interleaved burst via processor strobe, base low bits 2
    drive(0, 1, 1, 0, 8'hB6, "R2 cpu load");
    for (int i = 0; i < 3; i++) drive(1, 1, 0, 0, 8'h00, "R5 R6 interleaved step");
    drive(1, 1, 0, 0, 8'h11, "R8 wrap");
    drive(1, 1, 1, 0, 8'h22, "R9 hold");
    drive(1, 1, 1, 0, 8'h33, "R9 hold");
    // linear burst via controller strobe, base low bits 3
    drive(1, 0, 1, 1, 8'h4F, "R3 ctl load");
    for (int i = 0; i < 4; i++) drive(1, 1, 0, 1, 8'hFF, "R7 R8 linear step");
    // both strobes with step active
    drive(0, 0, 0, 1, 8'h91, "R4 both strobes");
    drive(1, 1, 0, 1, 8'h00, "R7 step");
    // mode change mid-burst
    drive(1, 1, 1, 0, 8'h00, "R10 mode change");
    drive(1, 1, 0, 0, 8'h00, "R10 mode applied");
    drive(1, 1, 0, 1, 8'h00, "R10 mode back");
    drive(1, 1, 1, 1, 8'hEE, "R11 upper fixed");
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      drive(($urandom % 5) != 0, ($urandom % 4) != 0, $urandom_range(0, 1) == 1,
            ($urandom % 7) == 0 ? ~order_lin : order_lin, a, "R5 R9 R11 random");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule